// File: doc/BRIEF.md
# Single-Wire Debug Serial Bit Engine

This block is the target-side bit engine of a debug link that runs over one open-drain wire. The wire rests high through a pull-up. The host starts every bit time by pulling the wire low, in either direction of transfer. Inside the target, all timing counts target-clock cycles. One bit time is 16 cycles, and bits move most significant first.

Software or a command decoder arms the engine with a one-cycle start pulse. The pulse selects the direction and whether the transfer is 8 or 16 bits long. When the target receives, the engine samples the synchronised wire at a fixed point in each bit. When the target sends, it holds the wire low for a zero. For a one it releases the wire and adds a single-cycle driven-high speedup pulse. The engine raises a one-cycle done pulse after the final bit. If the host goes quiet for 512 cycles between falling edges, the engine aborts, raises a one-cycle timeout pulse and returns to idle.

The pin appears as three signals: an input, an output enable and an output value. A driven low is enable=1 with value=0.

Top module: `sdbg_bit_engine`

## Requirements
- R1: After reset, and whenever no transfer is armed, line_oe_o, done_o, timeout_o and busy_o are all 0. A start_i pulse while idle sets busy_o in the next cycle.
- R2: A bit begins only on a host falling edge, seen through a two-stage synchroniser. Host edges while idle have no effect. While armed and awaiting an edge, the engine does not drive the wire.
- R3: In receive mode (dir_tx_i=0) the engine never drives the wire. It samples the synchronised wire when the bit phase counter reads 10; the counter reads 1 in the cycle after edge detection. With a host pulling low at a clock-edge boundary, this is the wire level 11 cycles after the drop. Bits are shifted in MSB first, so a byte ends in rx_data_o[7:0] with the upper bits zero, and a word fills rx_data_o[15:0].
- R4: In transmit mode (dir_tx_i=1), a zero bit drives the wire low (line_oe_o=1, line_o=0) while the phase counter is 1 to 12. That is from cycle 3 to cycle 14 after the host drop, counted as clock edges from the drop.
- R5: A one bit leaves the wire released, except for one cycle of driven high (line_oe_o=1, line_o=1) at phase 7, which is cycle 9 after the drop. The wire is never driven high for two cycles in a row.
- R6: Transmit data is sent MSB first: tx_data_i[7] first for a byte (len_word_i=0), tx_data_i[15] first for a word (len_word_i=1). After the 16th cycle of the last bit, done_o pulses for exactly one cycle and busy_o falls together with it.
- R7: While armed, if 512 cycles pass after a consumed host edge with no new edge, timeout_o pulses for one cycle, busy_o falls and the bit count is cleared. A gap just under that limit does not abort. A transfer started after a timeout runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that arms a transfer when idle |
| dir_tx_i | input | 1 | 1 = target sends, 0 = target receives (taken at start) |
| len_word_i | input | 1 | 1 = 16-bit transfer, 0 = 8-bit (taken at start) |
| tx_data_i | input | 16 | Data to send (taken at start) |
| rx_data_o | output | 16 | Received bits, right-aligned |
| busy_o | output | 1 | Transfer armed or in progress |
| done_o | output | 1 | One-cycle pulse after the last bit |
| timeout_o | output | 1 | One-cycle pulse on a host-silence abort |
| line_i | input | 1 | Wire level as seen at the pin |
| line_oe_o | output | 1 | 1 = target drives the wire |
| line_o | output | 1 | Value driven when line_oe_o is 1 |

## Verification
The bench models the wire as open-drain and checks the enable and value pattern of every transmitted bit cycle by cycle. A drive window that is one cycle off, or a speedup pulse that is late or two cycles wide, therefore shows up as a pattern mismatch. It times the abort to the exact cycle after the last host edge, and it runs a transfer whose edge gaps sit just under the limit: an off-by-one gap counter would either abort too early or fire a cycle late. Host edges while idle, and a transfer started right after an abort, expose a design that reacts to stray edges or keeps a stale bit count. Random receive data with host holds of 4 and 14 cycles catches a sample point or bit order in the wrong place.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_RX   = 2'd1,
      ENG_TX   = 2'd2
   } eng_state_e;

endpackage

// File: rtl/sdbg_sync.sv
// Multi-stage synchroniser for the wire plus falling-edge detect.
module sdbg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_s_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign line_s_o = chain_q[STAGES-1];
   assign fall_o   = prev_q && !chain_q[STAGES-1];
endmodule

// File: rtl/sdbg_bit_timer.sv
// Bit phase counter started by host edges, plus host-silence gap counter.
module sdbg_bit_timer #(
   parameter int BIT_CYCLES     = 16,
   parameter int TIMEOUT_CYCLES = 512,
   parameter int PW             = 4,
   parameter int GW             = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          fall_i,
   output logic [PW-1:0] phase_o,
   output logic          active_o,
   output logic          bit_end_o,
   output logic          expire_o
);
   logic [PW-1:0] phase_q;
   logic          active_q;
   logic [GW-1:0] gap_q;

   assign bit_end_o = active_q && (phase_q == PW'(BIT_CYCLES - 1));
   assign expire_o  = run_i && !fall_i && (gap_q == GW'(TIMEOUT_CYCLES - 1));
   assign phase_o   = phase_q;
   assign active_o  = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= '0;
         active_q <= 1'b0;
         gap_q    <= '0;
      end else if (!run_i) begin
         phase_q  <= '0;
         active_q <= 1'b0;
         gap_q    <= '0;
      end else begin
         gap_q <= fall_i ? '0 : gap_q + 1'b1;
         if (fall_i && (!active_q || bit_end_o)) begin
            active_q <= 1'b1;
            phase_q  <= PW'(1);
         end else if (bit_end_o) begin
            active_q <= 1'b0;
            phase_q  <= '0;
         end else if (active_q) begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sdbg_shifter.sv
// Transmit and receive shift registers with remaining-bit count.
module sdbg_shifter #(
   parameter int SHORT_BITS = 8,
   parameter int LONG_BITS  = 16,
   parameter int CW         = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic                 long_i,
   input  logic [LONG_BITS-1:0] tx_data_i,
   input  logic                 sample_i,
   input  logic                 sample_val_i,
   input  logic                 advance_i,
   input  logic                 clear_i,
   output logic                 tx_bit_o,
   output logic                 last_o,
   output logic [LONG_BITS-1:0] rx_data_o
);
   localparam int ALIGN = LONG_BITS - SHORT_BITS;

   logic [LONG_BITS-1:0] tx_q;
   logic [LONG_BITS-1:0] rx_q;
   logic [CW-1:0]        left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         left_q <= '0;
      end else if (load_i) begin
         tx_q   <= long_i ? tx_data_i : (tx_data_i << ALIGN);
         rx_q   <= '0;
         left_q <= long_i ? CW'(LONG_BITS) : CW'(SHORT_BITS);
      end else if (clear_i) begin
         left_q <= '0;
      end else begin
         if (sample_i) rx_q <= {rx_q[LONG_BITS-2:0], sample_val_i};
         if (advance_i) begin
            tx_q   <= tx_q << 1;
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign tx_bit_o  = tx_q[LONG_BITS-1];
   assign last_o    = (left_q == CW'(1));
   assign rx_data_o = rx_q;
endmodule

// File: rtl/sdbg_bit_engine.sv
module sdbg_bit_engine
   import sdbg_pkg::*;
#(
   parameter int SHORT_BITS     = 8,
   parameter int LONG_BITS      = 16,
   parameter int BIT_CYCLES     = 16,
   parameter int SAMPLE_AT      = 10,
   parameter int ZERO_HOLD_END  = 13,
   parameter int SPEEDUP_AT     = 7,
   parameter int TIMEOUT_CYCLES = 512,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 dir_tx_i,
   input  logic                 len_word_i,
   input  logic [LONG_BITS-1:0] tx_data_i,
   output logic [LONG_BITS-1:0] rx_data_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 timeout_o,
   input  logic                 line_i,
   output logic                 line_oe_o,
   output logic                 line_o
);
   localparam int PW = $clog2(BIT_CYCLES);
   localparam int GW = $clog2(TIMEOUT_CYCLES);
   localparam int CW = $clog2(LONG_BITS + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SAMPLE_AT < 1 || SAMPLE_AT >= BIT_CYCLES ||
       SPEEDUP_AT < 1 || SPEEDUP_AT >= BIT_CYCLES ||
       ZERO_HOLD_END < 2 || ZERO_HOLD_END >= BIT_CYCLES) begin : g_bad_phase
      $error("bit phase points must lie inside one bit time");
   end
   if (TIMEOUT_CYCLES <= BIT_CYCLES) begin : g_bad_timeout
      $error("TIMEOUT_CYCLES must exceed BIT_CYCLES");
   end
   if (SHORT_BITS < 1 || SHORT_BITS > LONG_BITS) begin : g_bad_len
      $error("SHORT_BITS must be between 1 and LONG_BITS");
   end

   eng_state_e    state_q;
   logic          done_q, timeout_q;
   logic          line_s, fall;
   logic [PW-1:0] phase;
   logic          active, bit_end, expire;
   logic          tx_bit, last_bit;
   logic          run, is_tx, is_rx, load, sample, advance, finishing;
   logic          drive_low, drive_high;

   assign run       = (state_q != ENG_IDLE);
   assign is_tx     = (state_q == ENG_TX);
   assign is_rx     = (state_q == ENG_RX);
   assign load      = start_i && !run;
   assign sample    = is_rx && active && (phase == PW'(SAMPLE_AT));
   assign advance   = run && bit_end;
   assign finishing = advance && last_bit;

   sdbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_i),
      .line_s_o (line_s),
      .fall_o   (fall)
   );

   sdbg_bit_timer #(
      .BIT_CYCLES     (BIT_CYCLES),
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
      .PW             (PW),
      .GW             (GW)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .fall_i    (fall),
      .phase_o   (phase),
      .active_o  (active),
      .bit_end_o (bit_end),
      .expire_o  (expire)
   );

   sdbg_shifter #(
      .SHORT_BITS (SHORT_BITS),
      .LONG_BITS  (LONG_BITS),
      .CW         (CW)
   ) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .long_i       (len_word_i),
      .tx_data_i    (tx_data_i),
      .sample_i     (sample),
      .sample_val_i (line_s),
      .advance_i    (advance),
      .clear_i      (expire),
      .tx_bit_o     (tx_bit),
      .last_o       (last_bit),
      .rx_data_o    (rx_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ENG_IDLE;
         done_q    <= 1'b0;
         timeout_q <= 1'b0;
      end else begin
         done_q    <= finishing;
         timeout_q <= expire && !finishing;
         if (load)                     state_q <= dir_tx_i ? ENG_TX : ENG_RX;
         else if (finishing || expire) state_q <= ENG_IDLE;
      end
   end

   assign drive_low  = is_tx && active && !tx_bit && (phase < PW'(ZERO_HOLD_END));
   assign drive_high = is_tx && active && tx_bit && (phase == PW'(SPEEDUP_AT));

   assign line_oe_o = drive_low || drive_high;
   assign line_o    = drive_high;
   assign busy_o    = run;
   assign done_o    = done_q;
   assign timeout_o = timeout_q;
endmodule

// File: rtl/sdbg_bit_engine_chk.sv
module sdbg_bit_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic rx_mode,
   input logic line_oe_o,
   input logic line_o,
   input logic done_o,
   input logic timeout_o
);
   p_line_free_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !line_oe_o);

   p_rx_never_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mode |-> !line_oe_o);

   p_speedup_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_oe_o && line_o) |=> !(line_oe_o && line_o));

   p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_timeout_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!busy_o && !done_o));

   p_timeout_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);
endmodule

bind sdbg_bit_engine sdbg_bit_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_o    (busy_o),
   .rx_mode   (is_rx),
   .line_oe_o (line_oe_o),
   .line_o    (line_o),
   .done_o    (done_o),
   .timeout_o (timeout_o)
);

// File: tb/tb_sdbg_bit_engine.sv
module tb_sdbg_bit_engine;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, dir_tx_i = 1'b0, len_word_i = 1'b0;
   logic [15:0] tx_data_i = '0;
   logic [15:0] rx_data_o;
   logic        busy_o, done_o, timeout_o, line_oe_o, line_o;
   logic        host_low = 1'b0;
   logic        line;

   int errors = 0, checks = 0;
   int done_cnt = 0, to_cnt = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // open-drain wire: low if host pulls or target drives low
   assign line = !(host_low || (line_oe_o && !line_o));

   sdbg_bit_engine dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_tx_i(dir_tx_i),
      .len_word_i(len_word_i), .tx_data_i(tx_data_i), .rx_data_o(rx_data_o),
      .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
      .line_i(line), .line_oe_o(line_oe_o), .line_o(line_o)
   );

   always @(negedge clk) begin
      if (rst_n && done_o)    done_cnt++;
      if (rst_n && timeout_o) to_cnt++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected pin pattern at negedge j after the host drop
   function automatic logic [1:0] exp_pin(input bit tx, input bit val, input int j);
      if (!tx)  return 2'b00;
      if (!val) return (j >= 3 && j <= 14) ? 2'b10 : 2'b00;
      return (j == 9) ? 2'b11 : 2'b00;
   endfunction

   task automatic host_bit(input bit tx, input bit val, output bit seen);
      int hold;
      logic [1:0] got, exp;
      int bad_j = 0;
      logic [1:0] bad_got = 2'b00, bad_exp = 2'b00;
      hold = tx ? 4 : (val ? 4 : 14);
      @(negedge clk);
      host_low = 1'b1;
      for (int j = 1; j <= 16; j++) begin
         @(negedge clk);
         got = {line_oe_o, line_o & line_oe_o};
         exp = exp_pin(tx, val, j);
         if (got !== exp && bad_j == 0) begin
            bad_j = j; bad_got = got; bad_exp = exp;
         end
         if (j == 10) seen = line;
         if (j == hold) host_low = 1'b0;
      end
      if (!tx)      chk(bad_j == 0, "R3", "no drive in receive", bad_got, bad_exp);
      else if (val) chk(bad_j == 0, "R5", "speedup pattern", bad_got, bad_exp);
      else          chk(bad_j == 0, "R4", "zero drive window", bad_got, bad_exp);
   endtask

   task automatic arm(input bit tx, input bit word, input logic [15:0] data);
      @(negedge clk);
      start_i = 1'b1; dir_tx_i = tx; len_word_i = word; tx_data_i = data;
      @(negedge clk);
      start_i = 1'b0; dir_tx_i = 1'b0; len_word_i = 1'b0; tx_data_i = '0;
      chk(busy_o === 1'b1, "R1", "busy after start", busy_o, 1);
   endtask

   task automatic xfer(input bit tx, input bit word, input logic [15:0] data,
                       input int extra_gap);
      int n, d0, t0;
      bit seen;
      logic [15:0] got = '0, exp;
      n = word ? 16 : 8;
      d0 = done_cnt; t0 = to_cnt;
      arm(tx, word, data);
      for (int b = n - 1; b >= 0; b--) begin
         host_bit(tx, data[b], seen);
         got = {got[14:0], seen};
         if (b != 0) repeat (extra_gap) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(done_cnt - d0 == 1, "R6", "single done pulse", done_cnt - d0, 1);
      chk(busy_o === 1'b0, "R6", "idle after done", busy_o, 0);
      chk(to_cnt == t0, "R7", "no timeout on gap", to_cnt - t0, 0);
      exp = word ? data : {8'h00, data[7:0]};
      if (tx) chk(got == exp, "R6", "sent bits msb first", got, exp);
      else    chk(rx_data_o === exp, "R3", "received data", rx_data_o, exp);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=expired expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      bit seen;
      int n;
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy_o, line_oe_o, done_o, timeout_o} === 4'b0, "R1", "reset state",
          {busy_o, line_oe_o, done_o, timeout_o}, 0);

      // R2: host edges while idle do nothing
      for (int k = 0; k < 3; k++) host_bit(1'b0, k[0], seen);
      repeat (3) @(negedge clk);
      chk(done_cnt == 0 && to_cnt == 0 && !busy_o, "R2", "idle edges ignored",
          done_cnt + to_cnt + busy_o, 0);

      // R2: armed transmit of a zero does not drive before the host edge
      arm(1'b1, 1'b0, 16'h0000);
      n = 0;
      repeat (20) begin @(negedge clk); if (line_oe_o) n++; end
      chk(n == 0, "R2", "no drive before first edge", n, 0);
      for (int b = 7; b >= 0; b--) host_bit(1'b1, 1'b0, seen);
      repeat (4) @(negedge clk);
      chk(done_cnt == 1, "R6", "done after all-zero byte", done_cnt, 1);

      // directed patterns
      xfer(1'b1, 1'b0, 16'h00FF, 0);
      xfer(1'b1, 1'b1, 16'hA55A, 0);
      xfer(1'b0, 1'b0, 16'h0081, 0);
      xfer(1'b0, 1'b1, 16'h8001, 0);

      // R7: gaps just under the limit are tolerated
      xfer(1'b0, 1'b0, 16'h00C3, 480);

      // R7: exact abort time after the last consumed edge
      n = to_cnt;
      arm(1'b0, 1'b1, 16'h0);
      host_bit(1'b0, 1'b1, seen);
      host_bit(1'b0, 1'b0, seen);
      begin
         int j;
         for (j = 17; j < 700; j++) begin
            @(negedge clk);
            if (timeout_o) break;
         end
         chk(j == 515, "R7", "timeout cycle after drop", j, 515);
      end
      @(negedge clk);
      chk(to_cnt - n == 1 && !busy_o, "R7", "one timeout pulse then idle",
          to_cnt - n, 1);
      xfer(1'b1, 1'b0, 16'h005A, 0);   // R7: fresh transfer after abort

      // constrained random transfers
      for (int r = 0; r < 10; r++) begin
         logic [15:0] d;
         d = 16'($urandom);
         xfer(1'($urandom), 1'($urandom), d, int'($urandom % 8));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule